// File: doc/BRIEF.md
# Predicated Vector Element Issue Unit

This unit sits between instruction decode and a multi-issue instruction FIFO. It accepts one decoded instruction in scalar form, together with a vector length, the number of an integer register that holds the element predicate, and a per-register table that marks each architectural register as vectorised or scalar. It turns that instruction into a series of element instructions and pushes them into the FIFO one per cycle. The register number of each vectorised operand steps up by one for each element. Elements whose predicate bit is clear are never pushed. The program counter is held until the unit pulses its completion output.

The predicate comes from the same register file as the operands, so an earlier instruction may still be writing it. The unit therefore acts as its own consumer of the scoreboard. It watches the pending-write vector and reads the predicate only once no write to that register is outstanding. It samples the predicate exactly once and keeps that copy for the whole expansion. Skipped elements cost no cycles: each cycle the unit goes straight to the next element whose predicate bit is set.

Top module: `vec_issue_unit`

## Requirements
- R1: After reset, with no instruction offered, push_o, done_o and stall_o are all low.
- R2: The unit pushes the element indices e with e < min(vl_i, XLEN) and predicate bit e set, in ascending order, one per cycle. Each push carries e on push_idx_o, and no other element is pushed.
- R3: For element e, each operand (destination, source 1, source 2) whose tag bit in vec_tag_i was set when the instruction was accepted appears as (base + e) mod 2^REG_W. An untagged operand keeps its base number. The opcode passes through unchanged.
- R4: While pend_wr_i has the bit of the predicate register set, the unit holds stall_o high, pushes nothing, and does not read the predicate. Pending writes to other registers cause no stall.
- R5: The predicate value is taken from pred_rdata_i in the first cycle after acceptance in which the hazard is clear. Later changes on pred_rdata_i have no effect on the expansion.
- R6: While fifo_full_i is high and elements remain, push_o is low, stall_o is high, and the same element is offered again once the FIFO has room.
- R7: done_o is a single-cycle pulse, asserted exactly once per instruction, in the cycle after the last push, with push_o low in that cycle.
- R8: When vl_i is 0, or every predicate bit below the vector length is clear, nothing is pushed and done_o pulses in the cycle after the predicate is sampled.
- R9: The instruction fields, predicate register number, vector length and tags are captured on the clock edge at which dec_valid_i is high while the unit is idle. Changes to those inputs during the expansion have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decoded instruction offered |
| dec_op_i | input | OP_W | Opcode |
| dec_rd_i | input | REG_W | Destination register base |
| dec_rs1_i | input | REG_W | Source 1 register base |
| dec_rs2_i | input | REG_W | Source 2 register base |
| pred_reg_i | input | REG_W | Register holding the predicate |
| vl_i | input | VL_W | Vector length |
| vec_tag_i | input | NREG | Vectorised tag per register (1 = vector) |
| pend_wr_i | input | NREG | Scoreboard pending-write bit per register |
| pred_raddr_o | output | REG_W | Register file read address for the predicate |
| pred_rdata_i | input | XLEN | Predicate register contents |
| fifo_full_i | input | 1 | Issue FIFO cannot accept a push |
| push_o | output | 1 | Element instruction pushed this cycle |
| push_op_o | output | OP_W | Pushed opcode |
| push_rd_o | output | REG_W | Pushed destination register |
| push_rs1_o | output | REG_W | Pushed source 1 register |
| push_rs2_o | output | REG_W | Pushed source 2 register |
| push_idx_o | output | IDX_W | Pushed element index |
| stall_o | output | 1 | Issue blocked by predicate hazard or full FIFO |
| done_o | output | 1 | Expansion finished; program counter may advance |

## Verification
The in-line assertions check on every cycle that no push happens while the FIFO is full or a stall is signalled, and that a pending predicate write holds the unit in its waiting state. They also check that the remaining-element mask stays frozen under back-pressure, that pushed indices stay below the vector length, and that completion is a single-cycle pulse. Other behaviours can only be shown by the bench's scenarios, which sweep every predicate value against every vector length with varied tags, hazard lengths and full patterns. These are the exact ascending element order, the stepped register numbers, the wrap of register numbers, the single sample of the predicate, and the fact that pending writes to other registers are ignored.

// File: rtl/vip_pkg.sv
package vip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2
  } vip_state_e;

  localparam int unsigned NUM_OPND = 3;
  localparam int unsigned OPND_RD  = 0;
  localparam int unsigned OPND_RS1 = 1;
  localparam int unsigned OPND_RS2 = 2;
endpackage

// File: rtl/vip_mask_gen.sv
module vip_mask_gen #(
  parameter int unsigned XLEN = 8,
  parameter int unsigned VL_W = 4
) (
  input  logic [XLEN-1:0] pred_i,
  input  logic [VL_W-1:0] vl_i,
  output logic [XLEN-1:0] mask_o
);
  logic [XLEN-1:0] len_mask;

  for (genvar i = 0; i < XLEN; i++) begin : g_len
    assign len_mask[i] = (VL_W'(i) < vl_i);
  end

  assign mask_o = pred_i & len_mask;
endmodule

// File: rtl/vip_pick_lowest.sv
module vip_pick_lowest #(
  parameter int unsigned XLEN  = 8,
  parameter int unsigned IDX_W = 3
) (
  input  logic [XLEN-1:0]  mask_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = XLEN - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |mask_i;
endmodule

// File: rtl/vip_reg_step.sv
module vip_reg_step #(
  parameter int unsigned REG_W = 5,
  parameter int unsigned IDX_W = 3
) (
  input  logic [REG_W-1:0] base_i,
  input  logic             vec_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [REG_W-1:0] reg_o
);
  logic [REG_W-1:0] offs;

  if (IDX_W >= REG_W) begin : g_trunc
    assign offs = idx_i[REG_W-1:0];
  end else begin : g_ext
    assign offs = {{(REG_W-IDX_W){1'b0}}, idx_i};
  end

  // wraps modulo the register count
  assign reg_o = vec_i ? base_i + offs : base_i;
endmodule

// File: rtl/vec_issue_unit.sv
module vec_issue_unit
  import vip_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned XLEN  = 8,
  parameter int unsigned OP_W  = 7,
  localparam int unsigned NREG  = 1 << REG_W,
  localparam int unsigned VL_W  = $clog2(XLEN + 1),
  localparam int unsigned IDX_W = (XLEN > 1) ? $clog2(XLEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dec_valid_i,
  input  logic [OP_W-1:0]  dec_op_i,
  input  logic [REG_W-1:0] dec_rd_i,
  input  logic [REG_W-1:0] dec_rs1_i,
  input  logic [REG_W-1:0] dec_rs2_i,
  input  logic [REG_W-1:0] pred_reg_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [NREG-1:0]  vec_tag_i,
  input  logic [NREG-1:0]  pend_wr_i,
  output logic [REG_W-1:0] pred_raddr_o,
  input  logic [XLEN-1:0]  pred_rdata_i,
  input  logic             fifo_full_i,
  output logic             push_o,
  output logic [OP_W-1:0]  push_op_o,
  output logic [REG_W-1:0] push_rd_o,
  output logic [REG_W-1:0] push_rs1_o,
  output logic [REG_W-1:0] push_rs2_o,
  output logic [IDX_W-1:0] push_idx_o,
  output logic             stall_o,
  output logic             done_o
);
  vip_state_e       state_q, state_d;
  logic [OP_W-1:0]  op_q;
  logic [REG_W-1:0] base_q [NUM_OPND];
  logic [REG_W-1:0] base_in [NUM_OPND];
  logic [REG_W-1:0] step_reg [NUM_OPND];
  logic [NUM_OPND-1:0] tag_q;
  logic [REG_W-1:0] preg_q;
  logic [VL_W-1:0]  vl_q;
  logic [XLEN-1:0]  mask_q, mask_init;
  logic             any_left;
  logic [IDX_W-1:0] cur_idx;
  logic             pred_busy;
  logic             accept;

  assign base_in[OPND_RD]  = dec_rd_i;
  assign base_in[OPND_RS1] = dec_rs1_i;
  assign base_in[OPND_RS2] = dec_rs2_i;

  assign accept    = (state_q == ST_IDLE) && dec_valid_i;
  assign pred_busy = pend_wr_i[preg_q];

  vip_mask_gen #(.XLEN(XLEN), .VL_W(VL_W)) u_mask (
    .pred_i (pred_rdata_i),
    .vl_i   (vl_q),
    .mask_o (mask_init)
  );

  vip_pick_lowest #(.XLEN(XLEN), .IDX_W(IDX_W)) u_pick (
    .mask_i (mask_q),
    .any_o  (any_left),
    .idx_o  (cur_idx)
  );

  for (genvar k = 0; k < NUM_OPND; k++) begin : g_opnd
    vip_reg_step #(.REG_W(REG_W), .IDX_W(IDX_W)) u_step (
      .base_i (base_q[k]),
      .vec_i  (tag_q[k]),
      .idx_i  (cur_idx),
      .reg_o  (step_reg[k])
    );
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (dec_valid_i) state_d = ST_WAIT;
      ST_WAIT:  if (!pred_busy) state_d = ST_ISSUE;
      ST_ISSUE: if (!any_left) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= '0;
      tag_q   <= '0;
      preg_q  <= '0;
      vl_q    <= '0;
      mask_q  <= '0;
      for (int k = 0; k < NUM_OPND; k++) base_q[k] <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        op_q   <= dec_op_i;
        preg_q <= pred_reg_i;
        vl_q   <= vl_i;
        for (int k = 0; k < NUM_OPND; k++) begin
          base_q[k] <= base_in[k];
          tag_q[k]  <= vec_tag_i[base_in[k]];
        end
      end
      if (state_q == ST_WAIT && !pred_busy) begin
        mask_q <= mask_init;
      end else if (push_o) begin
        mask_q[cur_idx] <= 1'b0;
      end
    end
  end

  assign pred_raddr_o = preg_q;
  assign push_o      = (state_q == ST_ISSUE) && any_left && !fifo_full_i;
  assign push_op_o   = op_q;
  assign push_rd_o   = step_reg[OPND_RD];
  assign push_rs1_o  = step_reg[OPND_RS1];
  assign push_rs2_o  = step_reg[OPND_RS2];
  assign push_idx_o  = cur_idx;
  assign done_o      = (state_q == ST_ISSUE) && !any_left;
  assign stall_o     = ((state_q == ST_WAIT) && pred_busy) ||
                       ((state_q == ST_ISSUE) && any_left && fifo_full_i);

  // R6
  no_push_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> !fifo_full_i);

  // R6
  hold_when_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ISSUE && any_left && fifo_full_i) |=> $stable(mask_q));

  // R4
  no_push_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(push_o && stall_o));

  // R4
  hazard_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && pred_busy) |=> (state_q == ST_WAIT));

  // R2
  idx_in_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> ({{(32-IDX_W){1'b0}}, push_idx_o} < {{(32-VL_W){1'b0}}, vl_q}));

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R7
  done_no_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !push_o);
endmodule

// File: tb/vec_issue_unit_tb.sv
`timescale 1ns/1ps
module vec_issue_unit_tb;
  localparam int REG_W = 5;
  localparam int XLEN  = 8;
  localparam int OP_W  = 7;
  localparam int NREG  = 1 << REG_W;
  localparam int VL_W  = $clog2(XLEN + 1);
  localparam int IDX_W = $clog2(XLEN);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             dec_valid = 1'b0;
  logic [OP_W-1:0]  dec_op = '0;
  logic [REG_W-1:0] dec_rd = '0, dec_rs1 = '0, dec_rs2 = '0, pred_reg = '0;
  logic [VL_W-1:0]  vl = '0;
  logic [NREG-1:0]  vec_tag = '0, pend_wr = '0;
  logic [REG_W-1:0] pred_raddr;
  logic [XLEN-1:0]  pred_rdata = '0;
  logic             fifo_full = 1'b0;
  logic             push, stall, done;
  logic [OP_W-1:0]  push_op;
  logic [REG_W-1:0] push_rd, push_rs1, push_rs2;
  logic [IDX_W-1:0] push_idx;

  int vectors = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  vec_issue_unit #(.REG_W(REG_W), .XLEN(XLEN), .OP_W(OP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .dec_valid_i(dec_valid), .dec_op_i(dec_op),
    .dec_rd_i(dec_rd), .dec_rs1_i(dec_rs1), .dec_rs2_i(dec_rs2),
    .pred_reg_i(pred_reg), .vl_i(vl), .vec_tag_i(vec_tag), .pend_wr_i(pend_wr),
    .pred_raddr_o(pred_raddr), .pred_rdata_i(pred_rdata), .fifo_full_i(fifo_full),
    .push_o(push), .push_op_o(push_op), .push_rd_o(push_rd), .push_rs1_o(push_rs1),
    .push_rs2_o(push_rs2), .push_idx_o(push_idx), .stall_o(stall), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [REG_W-1:0] stepped(input logic [REG_W-1:0] b,
                                               input bit t, input int e);
    return t ? REG_W'(int'(b) + e) : b;
  endfunction

  task automatic run_instr(input int n, input int vlen, input int pred,
                           input int hz, input bit full_on, input bit [2:0] tg,
                           input bit wrap);
    logic [REG_W-1:0] rd, rs1, rs2, pr, other;
    logic [OP_W-1:0] op;
    int exp_idx [$];
    int lim, cyc, guard, e;
    rd  = wrap ? REG_W'(NREG - 3) : REG_W'(n * 3);
    rs1 = REG_W'(rd + 1);
    rs2 = REG_W'(rd + 2);
    pr  = REG_W'(rd + 7);
    other = REG_W'(pr + 1);
    op  = OP_W'(n * 13 + 5);
    lim = (vlen < XLEN) ? vlen : XLEN;
    for (int i = 0; i < lim; i++) if (pred[i]) exp_idx.push_back(i);

    dec_valid = 1'b1; dec_op = op; dec_rd = rd; dec_rs1 = rs1; dec_rs2 = rs2;
    pred_reg = pr; vl = VL_W'(vlen); fifo_full = 1'b0;
    vec_tag = NREG'(n * 32'h9e3779b1);
    vec_tag[rd] = tg[0]; vec_tag[rs1] = tg[1]; vec_tag[rs2] = tg[2];
    pend_wr = '0;
    pend_wr[other] = 1'b1;               // R4: unrelated pending write
    if (hz > 0) pend_wr[pr] = 1'b1;
    pred_rdata = (hz > 0) ? ~XLEN'(pred) : XLEN'(pred);
    @(posedge clk); #1;
    // R9: scramble inputs after capture
    dec_op = ~op; dec_rd = ~rd; dec_rs1 = ~rs1; dec_rs2 = ~rs2; pred_reg = ~pr;
    vl = VL_W'(lim == 0 ? XLEN : 0); vec_tag = ~vec_tag; dec_valid = 1'b0;
    @(negedge clk);
    for (int h = 0; h < hz; h++) begin
      check(stall == 1'b1 && push == 1'b0 && done == 1'b0, "R4", "hazard stall",
            {stall, push, done}, 3'b100);
      @(negedge clk);
    end
    pend_wr[pr] = 1'b0;
    pred_rdata = XLEN'(pred);
    #1;
    if (hz == 0)
      check(stall == 1'b0, "R4", "no stall on other reg", stall, 0);
    @(posedge clk); #1;
    pred_rdata = ~XLEN'(pred);           // R5: must be ignored now
    pend_wr[pr] = 1'b1;
    cyc = 0; guard = 0;
    forever begin
      @(negedge clk);
      fifo_full = full_on && ((cyc % 3) == 1);
      #1;
      if (exp_idx.size() == 0) begin
        check(done == 1'b1 && push == 1'b0, (lim == 0 || pred == 0) ? "R8" : "R7",
              "done pulse", {done, push}, 2'b10);
        break;
      end
      if (fifo_full) begin
        check(push == 1'b0 && stall == 1'b1 && done == 1'b0, "R6", "full hold",
              {push, stall, done}, 3'b010);
      end else begin
        e = exp_idx.pop_front();
        check(push && !done && push_idx == IDX_W'(e), "R2", "element index",
              {push, done, push_idx}, {2'b10, IDX_W'(e)});
        check(push_op == op && push_rd == stepped(rd, tg[0], e) &&
              push_rs1 == stepped(rs1, tg[1], e) && push_rs2 == stepped(rs2, tg[2], e),
              "R3", "stepped regs", {push_op, push_rd, push_rs1, push_rs2},
              {op, stepped(rd, tg[0], e), stepped(rs1, tg[1], e), stepped(rs2, tg[2], e)});
      end
      cyc++; guard++;
      if (guard > 40) begin
        check(1'b0, "R2", "expansion hung", guard, 0);
        break;
      end
    end
    fifo_full = 1'b0;
    pend_wr = '0;
    @(negedge clk); #1;
    check(done == 1'b0 && push == 1'b0, "R7", "done single cycle", {done, push}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(push == 1'b0 && done == 1'b0 && stall == 1'b0, "R1", "in reset",
          {push, done, stall}, 0);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check(push == 1'b0 && done == 1'b0 && stall == 1'b0, "R1", "after reset",
          {push, done, stall}, 0);
    for (int v = 0; v <= XLEN + 1; v++) begin
      for (int p = 0; p < (1 << XLEN); p++) begin
        run_instr(v * 256 + p, v, p, (p ^ v) % 3, p[0] ^ v[0],
                  3'((p * 7 + v) % 8), 1'b0);
      end
    end
    // R3: register numbers wrap past the top of the file
    run_instr(1, XLEN, (1 << XLEN) - 1, 0, 1'b0, 3'b111, 1'b1);
    run_instr(2, XLEN, 8'ha5, 2, 1'b1, 3'b101, 1'b1);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      vectors++; fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", 200000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule